// File: doc/BRIEF.md
# Parallel-Input Signature Compactor

This block compacts several response streams from a circuit under test into one short signature. Every enabled clock cycle it shifts a linear feedback shift register in modular (internal-XOR) form. Each stage also XORs in its own bit of an n-bit parallel data word, so n output streams fold into one register at once. After the test sequence, the register content is compared with a known-good signature to give a pass/fail flag.

The register width and the feedback polynomial are parameters. A synchronous load puts a seed into the register before a run. A low enable freezes it. Because the update is linear, the final signature equals the XOR of the signatures that each input lane would leave on its own from a zero seed. A faulty response goes unnoticed with a probability of roughly 2^-n: about 1 in 16 at 4 bits and about 1 in 256 at 8 bits.

Top module: `sig_compactor`

## Requirements
- R1: While reset is asserted, and right after it is released, the signature output is all zeros.
- R2: When the load input is high at a clock edge, the signature becomes the seed input after that edge, whatever the enable.
- R3: When load and enable are both low at a clock edge, the signature keeps its value.
- R4: When enable is high and load is low, the register steps. Take the feedback polynomial as POLY, with bit i holding the coefficient of X^i and bit 0 set. Let m be the top stage S[n-1]. Then S0' = m ^ d0, and Si' = S[i-1] ^ (POLY[i] & m) ^ di for i > 0.
- R5: For the default width of 3 and POLY = 3'b011 (1 + X + X^3), a step gives S0' = S2^d0, S1' = S0^S2^d1 and S2' = S1^d2. With zero data and a nonzero seed, the state returns to the seed after exactly 7 steps and not earlier.
- R6: The match output is high in the same cycle exactly when the signature equals the golden input.
- R7: From a zero seed, the signature of a data sequence equals the XOR of the signatures of its n single-lane sequences. Each single-lane sequence keeps bit j of every word and zeroes the rest.
- R8: A zero state stepped with zero data stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_load_i | input | 1 | Load seed into the register at the next edge |
| seed_i | input | WIDTH | Seed value |
| step_en_i | input | 1 | Step the register with the data word |
| data_i | input | WIDTH | Parallel response bits, one per stage |
| golden_i | input | WIDTH | Expected fault-free signature |
| sig_o | output | WIDTH | Current signature |
| match_o | output | 1 | Signature equals golden value |

## Verification
The bench builds two instances. The first uses the default 3-bit register with 1 + X + X^3, where the stage equations and the seven-step period can be checked against hand-worked values. The second uses an 8-bit register with POLY = 8'h1D (1 + X^2 + X^3 + X^4 + X^8). Its middle taps are spread out, so a misplaced tap or lane shows up. Its eight lanes also give the superposition check on random data enough independent streams to mean something.

// File: rtl/misr_pkg.sv
package misr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } misr_op_e;

  // load wins over step
  function automatic misr_op_e decode_op(input logic load, input logic en);
    if (load)    return OP_LOAD;
    else if (en) return OP_STEP;
    else         return OP_HOLD;
  endfunction

endpackage

// File: rtl/misr_rst_sync.sv
module misr_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/misr_next.sv
module misr_next #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] POLY = 3'b011
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] next_o
);

  localparam int unsigned TOP = WIDTH - 1;

  logic fb;
  assign fb = state_i[TOP];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign next_o[i] = (POLY[i] & fb) ^ data_i[i];
    end else begin : g_rest
      assign next_o[i] = state_i[i-1] ^ (POLY[i] & fb) ^ data_i[i];
    end
  end

endmodule

// File: rtl/misr_state.sv
module misr_state
  import misr_pkg::*;
#(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  misr_op_e         op_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] state_o
);

  logic [WIDTH-1:0] state_d, state_q;
  logic             state_en;

  always_comb begin
    state_en = 1'b0;
    state_d  = state_q;
    unique case (op_i)
      OP_LOAD: begin state_en = 1'b1; state_d = seed_i; end
      OP_STEP: begin state_en = 1'b1; state_d = next_i; end
      default: begin state_en = 1'b0; state_d = state_q; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  load_takes_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (state_o == $past(seed_i)));

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(state_o));

endmodule

// File: rtl/misr_match.sv
module misr_match #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] sig_i,
  input  logic [WIDTH-1:0] golden_i,
  output logic             match_o
);

  logic [WIDTH-1:0] diff;
  assign diff    = sig_i ^ golden_i;
  assign match_o = ~|diff;

endmodule

// File: rtl/sig_compactor.sv
module sig_compactor
  import misr_pkg::*;
#(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] POLY = 3'b011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             step_en_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] golden_i,
  output logic [WIDTH-1:0] sig_o,
  output logic             match_o
);

  localparam int unsigned TOP = WIDTH - 1;

  logic             rst_n_sync;
  logic [WIDTH-1:0] state, next_state;
  misr_op_e         op;

  assign op = decode_op(seed_load_i, step_en_i);

  misr_rst_sync u_rst (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_n_sync)
  );

  misr_next #(.WIDTH(WIDTH), .POLY(POLY)) u_next (
    .state_i(state),
    .data_i (data_i),
    .next_o (next_state)
  );

  misr_state #(.WIDTH(WIDTH)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .op_i   (op),
    .seed_i (seed_i),
    .next_i (next_state),
    .state_o(state)
  );

  misr_match #(.WIDTH(WIDTH)) u_match (
    .sig_i   (state),
    .golden_i(golden_i),
    .match_o (match_o)
  );

  assign sig_o = state;

  // R4
  stage0_feedback_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (step_en_i && !seed_load_i) |=> (sig_o[0] == $past(sig_o[TOP] ^ data_i[0])));

  // R8
  zero_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (step_en_i && !seed_load_i && sig_o == '0 && data_i == '0) |=> (sig_o == '0));

endmodule

// File: tb/sig_compactor_tb_top.sv
`timescale 1ns/1ps
module sig_compactor_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  // 3-bit instance
  logic       ld3 = 0, en3 = 0, mt3;
  logic [2:0] sd3 = 0, d3 = 0, g3 = 0, s3;
  // 8-bit instance
  logic       ld8 = 0, en8 = 0, mt8;
  logic [7:0] sd8 = 0, d8 = 0, g8 = 0, s8;

  sig_compactor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .seed_load_i(ld3), .seed_i(sd3), .step_en_i(en3),
    .data_i(d3), .golden_i(g3), .sig_o(s3), .match_o(mt3));

  sig_compactor #(.WIDTH(8), .POLY(8'h1D)) dut8_i (
    .clk_i(clk), .rst_ni(rst_n), .seed_load_i(ld8), .seed_i(sd8), .step_en_i(en8),
    .data_i(d8), .golden_i(g8), .sig_o(s8), .match_o(mt8));

  function automatic logic [7:0] model(input logic [7:0] s, input logic [7:0] d,
                                       input logic [7:0] poly, input int w);
    logic [7:0] n = '0;
    logic m = s[w-1];
    for (int i = 0; i < w; i++)
      n[i] = ((i == 0) ? 1'b0 : s[i-1]) ^ (poly[i] & m) ^ d[i];
    return n;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic cyc3(input logic ld, input logic [2:0] sd, input logic en, input logic [2:0] d);
    @(negedge clk); ld3 = ld; sd3 = sd; en3 = en; d3 = d;
    @(posedge clk); #1;
    ld3 = 0; en3 = 0;
  endtask

  task automatic cyc8(input logic ld, input logic [7:0] sd, input logic en, input logic [7:0] d);
    @(negedge clk); ld8 = ld; sd8 = sd; en8 = en; d8 = d;
    @(posedge clk); #1;
    ld8 = 0; en8 = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset 3b", s3, 8'h0);
    chk("R1 in reset 8b", s8, 8'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release 3b", s3, 8'h0);
    chk("R1 after release 8b", s8, 8'h0);
  endtask

  task automatic t_load_hold();
    cyc3(1, 3'b101, 1, 3'b111);
    chk("R2 load wins over enable", s3, 8'h5);
    cyc3(0, 3'b010, 0, 3'b111);
    chk("R3 hold", s3, 8'h5);
    cyc3(0, 3'b000, 0, 3'b000);
    chk("R3 hold again", s3, 8'h5);
    cyc8(1, 8'hA7, 0, 8'h00);
    chk("R2 load 8b", s8, 8'hA7);
  endtask

  task automatic t_reference();
    cyc3(1, 3'b001, 0, 0);
    cyc3(0, 0, 1, 3'b000);
    chk("R5 001 step", s3, 8'h2);
    cyc3(1, 3'b100, 0, 0);
    cyc3(0, 0, 1, 3'b000);
    chk("R5 100 step", s3, 8'h3);
    cyc3(1, 3'b100, 0, 0);
    cyc3(0, 0, 1, 3'b101);
    chk("R5 data xor", s3, 8'h6);
    // period 7
    cyc3(1, 3'b001, 0, 0);
    for (int k = 1; k <= 7; k++) begin
      cyc3(0, 0, 1, 3'b000);
      if (k < 7) begin
        checks++;
        if (s3 == 3'b001) begin
          errors++;
          $display("FAIL R5 early return at step %0d: actual=%h expected!=1", k, s3);
        end
      end
    end
    chk("R5 period 7", s3, 8'h1);
  endtask

  task automatic t_general();
    logic [7:0] e = 8'h5C;
    cyc8(1, e, 0, 0);
    for (int k = 0; k < 20; k++) begin
      logic [7:0] d = 8'($urandom);
      cyc8(0, 0, 1, d);
      e = model(e, d, 8'h1D, 8);
    end
    chk("R4 8b random run", s8, e);
    e = 3'b110;
    cyc3(1, 3'b110, 0, 0);
    for (int k = 0; k < 12; k++) begin
      logic [2:0] d = 3'($urandom);
      cyc3(0, 0, 1, d);
      e = model(e, {5'b0, d}, 8'h03, 3);
    end
    chk("R4 3b random run", s3, e);
  endtask

  task automatic t_match();
    cyc3(1, 3'b011, 0, 0);
    g3 = 3'b011; #1;
    chk("R6 match high", {7'b0, mt3}, 8'h1);
    g3 = 3'b111; #1;
    chk("R6 match low", {7'b0, mt3}, 8'h0);
    g8 = s8; #1;
    chk("R6 match 8b", {7'b0, mt8}, 8'h1);
  endtask

  task automatic t_superpose();
    logic [7:0] seq [10];
    logic [7:0] full, acc;
    for (int k = 0; k < 10; k++) seq[k] = 8'($urandom);
    cyc8(1, 8'h00, 0, 0);
    for (int k = 0; k < 10; k++) cyc8(0, 0, 1, seq[k]);
    full = s8;
    acc = '0;
    for (int j = 0; j < 8; j++) begin
      cyc8(1, 8'h00, 0, 0);
      for (int k = 0; k < 10; k++) cyc8(0, 0, 1, seq[k] & (8'h01 << j));
      acc ^= s8;
    end
    chk("R7 superposition", full, acc);
  endtask

  task automatic t_zero();
    cyc8(1, 8'h00, 0, 0);
    for (int k = 0; k < 5; k++) cyc8(0, 0, 1, 8'h00);
    chk("R8 zero stays zero", s8, 8'h00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!done && cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_hold();
    t_reference();
    t_general();
    t_match();
    t_superpose();
    t_zero();
    t_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule